// File: doc/BRIEF.md
# Overriding Predictor Check and Fetch Resteer

This block watches the fetch stream next to a small first-level branch predictor that steers fetch every cycle without gaps. Each fetch group the fast predictor steers is handed to the block as a record holding its sequence tag, the fast direction and target, and the group's fall-through address. A larger second-level predictor produces its own verdict on the same group a fixed number of cycles later. The block pairs each slow verdict with the record it belongs to. When the two disagree, the block tells the fetch queue to drop every entry younger than the disagreeing group, and tells fetch to restart at the second-level answer.

An override costs a short bubble. Groups that fetch produced on the wrong path are discarded, and so are the slow verdicts that later arrive for them. A redirect coming from the execution stage wins over an override raised in the same cycle. It also cancels every check still in flight. A saturating counter reports how many overrides have been raised.

Top module: `override_resteer`

## Requirements
- R1: While reset is held and after its release, `flush_valid`, `flush_all` and `redir_valid` are 0 and `override_count` is 0.
- R2: When the slow verdict agrees with the fast one, no flush and no redirect is raised. Agreement means both say not taken, or both say taken with equal targets. When both say not taken, the targets are not compared.
- R3: A record is presented in cycle k and its slow verdict arrives in cycle k+LAT. If the slow predictor says taken and the fast one said not taken, then in cycle k+LAT+1 the block raises `flush_valid` and `redir_valid` for one cycle, with `flush_all`=0, `flush_tag` equal to the record's tag, and `redir_pc` equal to the slow target.
- R4: If the fast predictor said taken and the slow one says not taken, the override of R3 is raised with `redir_pc` equal to the record's fall-through address.
- R5: If both say taken but the targets differ, the override of R3 is raised with `redir_pc` equal to the slow target.
- R6: After an override, three kinds of record are discarded: records still waiting for their slow verdict, the record presented in the override's decision cycle, and the record presented in the cycle the redirect is shown. Their later slow verdicts raise nothing. A record presented one cycle after the redirect is checked normally.
- R7: An execution redirect in cycle e raises `flush_valid`, `redir_valid` and `flush_all`=1 in cycle e+1, with `redir_pc` equal to the execution address. A disagreeing slow verdict in cycle e is suppressed and is not counted.
- R8: An execution redirect cancels every pending check. The slow verdicts of records presented before it raise nothing.
- R9: A slow verdict that has no live record LAT cycles earlier raises nothing.
- R10: `override_count` rises by one for each override, in the cycle the override is shown. It stays at 2^CNT_W-1 once it reaches that value.
- R11: An override is never visible earlier than cycle k+LAT+1. `redir_valid` is 0 in cycle k+LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A fetch-group record is presented this cycle |
| grp_tag | input | TAG_W | Sequence tag of the group |
| grp_taken | input | 1 | Fast predictor direction |
| grp_target | input | ADDR_W | Fast predictor target |
| grp_fallthru | input | ADDR_W | Address following the group |
| slow_valid | input | 1 | Second-level verdict present for the record from LAT cycles ago |
| slow_taken | input | 1 | Second-level direction |
| slow_target | input | ADDR_W | Second-level target |
| exe_valid | input | 1 | Redirect from the execution stage |
| exe_pc | input | ADDR_W | Restart address from execution |
| flush_valid | output | 1 | Fetch-queue flush request |
| flush_all | output | 1 | 1: flush the whole queue (execution redirect); 0: flush entries younger than `flush_tag` |
| flush_tag | output | TAG_W | Tag of the disagreeing group |
| redir_valid | output | 1 | Fetch redirect request |
| redir_pc | output | ADDR_W | Fetch restart address |
| override_count | output | CNT_W | Saturating count of overrides |

## Verification
The assertions take two things for granted about the inputs. First, the second-level verdict for a group arrives exactly LAT cycles after its record, with at most one verdict per cycle. Second, an execution redirect is a single-cycle event that carries its own address. The stimulus respects both. Every slow verdict is driven in the cycle LAT after its record, including verdicts for groups the block has already discarded. Records and verdicts overlap only where they keep that alignment. The bench never drives a verdict that would have to pair with two records.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
   localparam int MAX_LAT = 4;
endpackage

// File: rtl/ovr_delay_line.sv
module ovr_delay_line
   import ovr_pkg::*;
#(
   parameter int LAT    = 2,
   parameter int TAG_W  = 6,
   parameter int ADDR_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kill,
   input  logic              in_valid,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic              in_taken,
   input  logic [ADDR_W-1:0] in_tgt,
   input  logic [ADDR_W-1:0] in_ft,
   output logic              out_valid,
   output logic [TAG_W-1:0]  out_tag,
   output logic              out_taken,
   output logic [ADDR_W-1:0] out_tgt,
   output logic [ADDR_W-1:0] out_ft,
   output logic              any_valid
);
   logic [LAT-1:0]    vld;
   logic [TAG_W-1:0]  tg  [LAT];
   logic              tk  [LAT];
   logic [ADDR_W-1:0] tgt [LAT];
   logic [ADDR_W-1:0] ft  [LAT];

   if (LAT < 1 || LAT > MAX_LAT) begin : g_bad_lat
      $error("ovr_delay_line: LAT out of range");
   end

   if (LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n)    vld <= '0;
         else if (kill) vld <= '0;
         else           vld <= in_valid;
      end
   end else begin : g_chain
      always_ff @(posedge clk) begin
         if (!rst_n)    vld <= '0;
         else if (kill) vld <= '0;
         else           vld <= {vld[LAT-2:0], in_valid};
      end
   end

   always_ff @(posedge clk) begin
      tg[0]  <= in_tag;
      tk[0]  <= in_taken;
      tgt[0] <= in_tgt;
      ft[0]  <= in_ft;
      for (int i = 1; i < LAT; i++) begin
         tg[i]  <= tg[i-1];
         tk[i]  <= tk[i-1];
         tgt[i] <= tgt[i-1];
         ft[i]  <= ft[i-1];
      end
   end

   assign out_valid = vld[LAT-1];
   assign out_tag   = tg[LAT-1];
   assign out_taken = tk[LAT-1];
   assign out_tgt   = tgt[LAT-1];
   assign out_ft    = ft[LAT-1];
   assign any_valid = |vld;

   AST_KILL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !any_valid); // R8
endmodule

// File: rtl/ovr_compare.sv
module ovr_compare #(
   parameter int ADDR_W = 48
) (
   input  logic              fast_taken,
   input  logic [ADDR_W-1:0] fast_tgt,
   input  logic [ADDR_W-1:0] fast_ft,
   input  logic              slow_taken,
   input  logic [ADDR_W-1:0] slow_tgt,
   output logic              mismatch,
   output logic [ADDR_W-1:0] fix_pc
);
   logic dir_diff;
   logic tgt_diff;

   always_comb begin
      dir_diff = fast_taken ^ slow_taken;
      tgt_diff = fast_taken & slow_taken & (fast_tgt != slow_tgt);
      mismatch = dir_diff | tgt_diff;
      fix_pc   = slow_taken ? slow_tgt : fast_ft;
   end
endmodule

// File: rtl/ovr_counter.sv
module ovr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 1) begin : g_bad_cnt
      $error("ovr_counter: CNT_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        count <= '0;
      else if (inc && count != CNT_MAX)  count <= count + 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (count == $past(count)) || (count == $past(count) + 1'b1)); // R10
   AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX) |=> (count == CNT_MAX)); // R10
endmodule

// File: rtl/override_resteer.sv
module override_resteer
   import ovr_pkg::*;
#(
   parameter int LAT    = 2,
   parameter int TAG_W  = 6,
   parameter int ADDR_W = 48,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grp_valid,
   input  logic [TAG_W-1:0]  grp_tag,
   input  logic              grp_taken,
   input  logic [ADDR_W-1:0] grp_target,
   input  logic [ADDR_W-1:0] grp_fallthru,
   input  logic              slow_valid,
   input  logic              slow_taken,
   input  logic [ADDR_W-1:0] slow_target,
   input  logic              exe_valid,
   input  logic [ADDR_W-1:0] exe_pc,
   output logic              flush_valid,
   output logic              flush_all,
   output logic [TAG_W-1:0]  flush_tag,
   output logic              redir_valid,
   output logic [ADDR_W-1:0] redir_pc,
   output logic [CNT_W-1:0]  override_count
);
   if (TAG_W < 1 || ADDR_W < 2 || LAT > MAX_LAT) begin : g_bad_cfg
      $error("override_resteer: bad parameter set");
   end

   logic              dl_valid, dl_taken, dl_any;
   logic [TAG_W-1:0]  dl_tag;
   logic [ADDR_W-1:0] dl_tgt, dl_ft;
   logic              mismatch;
   logic [ADDR_W-1:0] fix_pc;
   logic              override, kill, capture;
   logic              redir_q, all_q;
   logic [TAG_W-1:0]  tag_q;
   logic [ADDR_W-1:0] pc_q;

   always_comb begin
      override = dl_valid & slow_valid & mismatch & ~exe_valid;
      kill     = override | exe_valid;
      capture  = grp_valid & ~kill & ~redir_q;
   end

   ovr_delay_line #(.LAT(LAT), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_dl (
      .clk(clk), .rst_n(rst_n), .kill(kill),
      .in_valid(capture), .in_tag(grp_tag), .in_taken(grp_taken),
      .in_tgt(grp_target), .in_ft(grp_fallthru),
      .out_valid(dl_valid), .out_tag(dl_tag), .out_taken(dl_taken),
      .out_tgt(dl_tgt), .out_ft(dl_ft), .any_valid(dl_any)
   );

   ovr_compare #(.ADDR_W(ADDR_W)) u_cmp (
      .fast_taken(dl_taken), .fast_tgt(dl_tgt), .fast_ft(dl_ft),
      .slow_taken(slow_taken), .slow_tgt(slow_target),
      .mismatch(mismatch), .fix_pc(fix_pc)
   );

   ovr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(override), .count(override_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redir_q <= 1'b0;
         all_q   <= 1'b0;
         tag_q   <= '0;
         pc_q    <= '0;
      end else begin
         redir_q <= kill;
         all_q   <= exe_valid;
         tag_q   <= dl_tag;
         pc_q    <= exe_valid ? exe_pc : fix_pc;
      end
   end

   assign flush_valid = redir_q;
   assign flush_all   = all_q;
   assign flush_tag   = tag_q;
   assign redir_valid = redir_q;
   assign redir_pc    = pc_q;

   AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> !dl_any); // R6
   AST_NO_CHAINED_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> !(redir_valid && !flush_all)); // R6
   AST_EXEC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      exe_valid |=> (redir_valid && flush_all && redir_pc == $past(exe_pc))); // R7
   AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid && !flush_all) |-> ($past(slow_valid) && $past(dl_valid))); // R3
endmodule

// File: tb/override_resteer_bench.sv
`timescale 1ns/1ps
module override_resteer_bench;
   localparam int LAT = 2, TAG_W = 4, ADDR_W = 16, CNT_W = 3;
   localparam int NV = 8;
   // {f_taken, f_tgt, f_ft, s_taken, s_tgt, exp_redir, exp_pc}
   localparam logic [66:0] VEC [NV] = '{
      {1'b1, 16'h1000, 16'h0104, 1'b1, 16'h1000, 1'b0, 16'h0000},
      {1'b0, 16'h0000, 16'h0204, 1'b0, 16'h3333, 1'b0, 16'h0000},
      {1'b0, 16'h0000, 16'h0304, 1'b1, 16'h4400, 1'b1, 16'h4400},
      {1'b1, 16'h5000, 16'h0404, 1'b0, 16'h0000, 1'b1, 16'h0404},
      {1'b1, 16'h6000, 16'h0504, 1'b1, 16'h6100, 1'b1, 16'h6100},
      {1'b1, 16'h7000, 16'h0604, 1'b1, 16'h7000, 1'b0, 16'h0000},
      {1'b0, 16'h0000, 16'h0704, 1'b1, 16'h0010, 1'b1, 16'h0010},
      {1'b1, 16'h8000, 16'h0804, 1'b0, 16'h8000, 1'b1, 16'h0804}
   };

   logic clk = 0, rst_n = 0;
   logic grp_valid = 0, grp_taken = 0, slow_valid = 0, slow_taken = 0, exe_valid = 0;
   logic [TAG_W-1:0] grp_tag = '0;
   logic [ADDR_W-1:0] grp_target = '0, grp_fallthru = '0, slow_target = '0, exe_pc = '0;
   logic flush_valid, flush_all, redir_valid;
   logic [TAG_W-1:0] flush_tag;
   logic [ADDR_W-1:0] redir_pc;
   logic [CNT_W-1:0] override_count;
   int n_run = 0, n_fail = 0, exp_cnt = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   override_resteer #(.LAT(LAT), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_override_resteer (
      .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_tag(grp_tag),
      .grp_taken(grp_taken), .grp_target(grp_target), .grp_fallthru(grp_fallthru),
      .slow_valid(slow_valid), .slow_taken(slow_taken), .slow_target(slow_target),
      .exe_valid(exe_valid), .exe_pc(exe_pc), .flush_valid(flush_valid),
      .flush_all(flush_all), .flush_tag(flush_tag), .redir_valid(redir_valid),
      .redir_pc(redir_pc), .override_count(override_count)
   );

   task automatic tick(); @(negedge clk); endtask

   task automatic chk(string req, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic grp(input logic [TAG_W-1:0] t, input logic tk, input logic [ADDR_W-1:0] tg, input logic [ADDR_W-1:0] ft);
      grp_valid = 1; grp_tag = t; grp_taken = tk; grp_target = tg; grp_fallthru = ft;
   endtask

   task automatic slow(input logic tk, input logic [ADDR_W-1:0] tg);
      slow_valid = 1; slow_taken = tk; slow_target = tg;
   endtask

   task automatic expect_ovr(string req, int tag, int pc);
      if (exp_cnt < 7) exp_cnt++;
      chk(req, "redir_valid", int'(redir_valid), 1);
      chk(req, "flush_valid", int'(flush_valid), 1);
      chk(req, "flush_all", int'(flush_all), 0);
      chk(req, "flush_tag", int'(flush_tag), tag);
      chk(req, "redir_pc", int'(redir_pc), pc);
      chk("R10", "override_count", int'(override_count), exp_cnt);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) tick();
      chk("R1", "redir_valid", int'(redir_valid), 0);
      chk("R1", "flush_valid", int'(flush_valid), 0);
      chk("R1", "override_count", int'(override_count), 0);
      rst_n = 1;
      tick();
      chk("R1", "flush_all", int'(flush_all), 0);

      // Table walk: R2..R5, R11
      for (int i = 0; i < NV; i++) begin
         logic [66:0] v;
         string rq;
         v = VEC[i];
         grp(TAG_W'(i), v[66], v[65:50], v[49:34]);
         tick();
         grp_valid = 0;
         repeat (LAT - 1) tick();
         chk("R11", "redir_valid early", int'(redir_valid), 0);
         slow(v[33], v[32:17]);
         tick();
         slow_valid = 0;
         if (!v[16]) rq = "R2";
         else if (!v[33]) rq = "R4";
         else if (v[66]) rq = "R5";
         else rq = "R3";
         if (v[16]) expect_ovr(rq, i, int'(v[15:0]));
         else begin
            chk(rq, "redir_valid", int'(redir_valid), 0);
            chk(rq, "override_count", int'(override_count), exp_cnt);
         end
         tick(); tick();
      end

      // R6: wrong-path records are dropped; next one is checked
      grp(4'd1, 1'b0, 16'h0, 16'h0A04); tick();           // c0
      grp(4'd2, 1'b0, 16'h0, 16'h0B04); tick();           // c1
      grp(4'd3, 1'b0, 16'h0, 16'h0C04); slow(1'b1, 16'hA000); tick(); // c2
      expect_ovr("R6", 1, 16'hA000);                       // c3
      grp(4'd4, 1'b0, 16'h0, 16'h0D04); slow(1'b1, 16'hB000); tick();
      chk("R6", "younger in flight", int'(redir_valid), 0); // c4
      grp(4'd5, 1'b0, 16'h0, 16'h0E04); slow(1'b1, 16'hC000); tick();
      grp_valid = 0;
      chk("R6", "decision-cycle group", int'(redir_valid), 0); // c5
      slow(1'b1, 16'hD000); tick();
      chk("R6", "redirect-cycle group", int'(redir_valid), 0); // c6
      slow(1'b1, 16'hE000); tick();
      slow_valid = 0;
      expect_ovr("R6", 5, 16'hE000);                       // c7
      tick(); tick();

      // R7: execution redirect beats an override in the same cycle
      grp(4'd6, 1'b0, 16'h0, 16'h0F04); tick();
      grp_valid = 0; tick();
      slow(1'b1, 16'h9999); exe_valid = 1; exe_pc = 16'hABC0; tick();
      slow_valid = 0; exe_valid = 0;
      chk("R7", "redir_valid", int'(redir_valid), 1);
      chk("R7", "flush_all", int'(flush_all), 1);
      chk("R7", "redir_pc", int'(redir_pc), 16'hABC0);
      chk("R7", "override_count", int'(override_count), exp_cnt);
      tick(); tick();

      // R8: execution redirect cancels pending checks
      grp(4'd7, 1'b0, 16'h0, 16'h1104); tick();
      grp_valid = 0; exe_valid = 1; exe_pc = 16'h5550; tick();
      exe_valid = 0; slow(1'b1, 16'h7777);
      chk("R8", "exec flush_all", int'(flush_all), 1);
      tick();
      slow_valid = 0;
      chk("R8", "cancelled check", int'(redir_valid), 0);
      tick(); tick();

      // R9: verdict with no live record
      slow(1'b1, 16'h4321); tick();
      slow_valid = 0;
      chk("R9", "orphan verdict", int'(redir_valid), 0);
      tick();

      // R10: saturation
      grp(4'd8, 1'b1, 16'h2000, 16'h1204); tick();
      grp_valid = 0; tick();
      slow(1'b0, 16'h0); tick();
      slow_valid = 0;
      expect_ovr("R10", 8, 16'h1204);
      chk("R10", "saturated", int'(override_count), 7);
      tick();

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule